// File: doc/BRIEF.md
# USB Device Address Control Unit

This unit keeps the USB device address and the device-enable flag that a local processor programs through a command-style parallel register port. It holds two copies of that information. The first is the programmed register, which the processor writes and reads back. The second is the live address and enable, which the serial engine uses when it matches incoming tokens.

A programmed value does not reach the live copy when the processor writes it. The write only marks the value as pending. The value moves to the live copy when the serial engine reports that the host acknowledged the empty status-stage packet. That packet ends the Set Address control transfer, so tokens that are already in flight keep matching the old address.

A USB bus reset forces the live address to zero and enables the device. It leaves the programmed register untouched and throws away any value still pending.

Top module: `usb_devaddr_ctrl`

## Requirements
- R1: After power-up reset the programmed register reads 0x00, the live address is 0, the live enable is 0, `no_match` is 1 and nothing is pending.
- R2: A strobe with code 0xB6 stores the low 8 bits of the data word into the programmed register and ignores the upper byte. Register bit 7 is the enable and bits 6..0 are the address. A strobe with code 0xB7 drives `cmd_rvalid` high for one cycle on the following cycle, with `cmd_rdata` holding the register value zero-extended. The register value used is the one from before any write in the same cycle.
- R3: A write does not change the live address or the live enable by itself. On the clock edge that samples `status_ack` while a value is pending, and with no bus reset, the live address takes register bits 6..0 and the live enable takes register bit 7. At every other edge the live outputs hold, except for bus reset.
- R4: `status_ack` while nothing is pending has no effect.
- R5: On the edge that samples `bus_reset`, the live address becomes 0 and the live enable becomes 1. The programmed register keeps its value.
- R6: `bus_reset` clears the pending flag, even when a write occurs in the same cycle. A later `status_ack` then leaves the live outputs unchanged. When `bus_reset` and `status_ack` arrive together, the bus reset wins.
- R7: Strobes with any code other than 0xB6 or 0xB7 change no state and produce no read response.
- R8: `no_match` is high exactly when the live enable is low.
- R9: When a write and `status_ack` arrive in the same cycle with a value already pending, the live outputs take the older register value. The new value stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 8 | Command byte |
| cmd_wdata | input | 16 | Write data word |
| cmd_rdata | output | 16 | Read data word, valid while `cmd_rvalid` is high |
| cmd_rvalid | output | 1 | Read response strobe |
| bus_reset | input | 1 | USB bus reset pulse from the serial engine |
| status_ack | input | 1 | Host ACK of the status-stage empty packet |
| live_addr | output | 7 | Address used for token matching |
| live_en | output | 1 | Device enable used for token matching |
| no_match | output | 1 | Tells the serial engine to answer no token |

## Verification
The hardest situations to reach are the collisions, because they only show up when a strobe lands in the same cycle as another event. One case is a write that coincides with a status ACK while an older value is pending. The other is a bus reset that coincides with a write or with an ACK. The bench drives these collisions on purpose within single cycles. It first writes and leaves a value pending, then issues the colliding pair. A behavioural model, updated every edge, tracks which register value should commit. Read-back strobes after each collision show that the processor-visible register survived the bus reset.

// File: rtl/usb_devaddr_pkg.sv
`timescale 1ns/1ps
package usb_devaddr_pkg;
    localparam int DEF_ADDR_W  = 7;
    localparam int DEF_DATA_W  = 16;
    localparam int DEF_CODE_W  = 8;
    localparam logic [7:0] DEF_WR_CODE = 8'hB6;
    localparam logic [7:0] DEF_RD_CODE = 8'hB7;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_READ  = 2'd2
    } cmd_kind_t;
endpackage

// File: rtl/usb_devaddr_cmd_dec.sv
`timescale 1ns/1ps
module usb_devaddr_cmd_dec
    import usb_devaddr_pkg::*;
#(
    parameter int                CODE_W  = DEF_CODE_W,
    parameter logic [CODE_W-1:0] WR_CODE = DEF_WR_CODE,
    parameter logic [CODE_W-1:0] RD_CODE = DEF_RD_CODE
) (
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    output cmd_kind_t         cmd_kind
);
    // Unknown codes decode to CMD_NONE and touch nothing (R7).
    always_comb begin
        cmd_kind = CMD_NONE;
        if (cmd_valid) begin
            if (cmd_code == WR_CODE)      cmd_kind = CMD_WRITE;
            else if (cmd_code == RD_CODE) cmd_kind = CMD_READ;
        end
    end
endmodule

// File: rtl/usb_devaddr_prog_reg.sv
`timescale 1ns/1ps
module usb_devaddr_prog_reg
    import usb_devaddr_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    localparam int REG_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_kind_t         cmd_kind,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              bus_reset,
    input  logic              status_ack,
    output logic [REG_W-1:0]  prog_val,
    output logic              pending,
    output logic [DATA_W-1:0] cmd_rdata,
    output logic              cmd_rvalid
);
    typedef struct packed {
        logic [REG_W-1:0]  val;
        logic              pend;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } prog_state_t;

    prog_state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        // Read returns the value held before this cycle's write (R2).
        if (cmd_kind == CMD_READ) begin
            st_d.rvalid = 1'b1;
            st_d.rdata  = DATA_W'(st_q.val);
        end
        if (cmd_kind == CMD_WRITE) begin
            st_d.val = cmd_wdata[REG_W-1:0];
        end
        // Pending: bus reset discards, a write sets, an ACK consumes.
        if (bus_reset) begin
            st_d.pend = 1'b0;
        end else if (cmd_kind == CMD_WRITE) begin
            st_d.pend = 1'b1;
        end else if (status_ack) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prog_val   = st_q.val;
    assign pending    = st_q.pend;
    assign cmd_rdata  = st_q.rdata;
    assign cmd_rvalid = st_q.rvalid;
endmodule

// File: rtl/usb_devaddr_live.sv
`timescale 1ns/1ps
module usb_devaddr_live
    import usb_devaddr_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    localparam int REG_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  prog_val,
    input  logic              pending,
    input  logic              status_ack,
    input  logic              bus_reset,
    output logic [ADDR_W-1:0] live_addr,
    output logic              live_en,
    output logic              no_match
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              en;
    } live_state_t;

    live_state_t st_d, st_q;
    logic        commit;

    // An ACK counts only with something pending; bus reset wins (R3, R4, R6).
    assign commit = status_ack & pending & ~bus_reset;

    always_comb begin
        st_d = st_q;
        if (bus_reset) begin
            st_d.addr = '0;
            st_d.en   = 1'b1;
        end else if (commit) begin
            st_d.addr = prog_val[ADDR_W-1:0];
            st_d.en   = prog_val[REG_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live_addr = st_q.addr;
    assign live_en   = st_q.en;
    assign no_match  = ~st_q.en;
endmodule

// File: rtl/usb_devaddr_ctrl.sv
`timescale 1ns/1ps
module usb_devaddr_ctrl
    import usb_devaddr_pkg::*;
#(
    parameter int                ADDR_W  = DEF_ADDR_W,
    parameter int                DATA_W  = DEF_DATA_W,
    parameter int                CODE_W  = DEF_CODE_W,
    parameter logic [CODE_W-1:0] WR_CODE = DEF_WR_CODE,
    parameter logic [CODE_W-1:0] RD_CODE = DEF_RD_CODE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic [DATA_W-1:0] cmd_rdata,
    output logic              cmd_rvalid,
    input  logic              bus_reset,
    input  logic              status_ack,
    output logic [ADDR_W-1:0] live_addr,
    output logic              live_en,
    output logic              no_match
);
    localparam int REG_W = ADDR_W + 1;

    cmd_kind_t        cmd_kind;
    logic [REG_W-1:0] prog_val;
    logic             pending;

    usb_devaddr_cmd_dec #(
        .CODE_W (CODE_W),
        .WR_CODE(WR_CODE),
        .RD_CODE(RD_CODE)
    ) u_dec (
        .cmd_valid(cmd_valid),
        .cmd_code (cmd_code),
        .cmd_kind (cmd_kind)
    );

    usb_devaddr_prog_reg #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_kind  (cmd_kind),
        .cmd_wdata (cmd_wdata),
        .bus_reset (bus_reset),
        .status_ack(status_ack),
        .prog_val  (prog_val),
        .pending   (pending),
        .cmd_rdata (cmd_rdata),
        .cmd_rvalid(cmd_rvalid)
    );

    usb_devaddr_live #(
        .ADDR_W(ADDR_W)
    ) u_live (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_val  (prog_val),
        .pending   (pending),
        .status_ack(status_ack),
        .bus_reset (bus_reset),
        .live_addr (live_addr),
        .live_en   (live_en),
        .no_match  (no_match)
    );
endmodule

// File: rtl/usb_devaddr_ctrl_chk.sv
`timescale 1ns/1ps
module usb_devaddr_ctrl_chk #(
    parameter int                ADDR_W  = 7,
    parameter int                CODE_W  = 8,
    parameter logic [CODE_W-1:0] WR_CODE = 8'hB6,
    parameter logic [CODE_W-1:0] RD_CODE = 8'hB7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic [CODE_W-1:0] cmd_code,
    input logic              cmd_rvalid,
    input logic              bus_reset,
    input logic              status_ack,
    input logic [ADDR_W:0]   prog_val,
    input logic              pending,
    input logic [ADDR_W-1:0] live_addr,
    input logic              live_en,
    input logic              no_match
);
    a_r2_read_response: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == RD_CODE) |=> cmd_rvalid);

    a_r3_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (status_ack && pending && !bus_reset) |=>
            (live_addr == $past(prog_val[ADDR_W-1:0]) && live_en == $past(prog_val[ADDR_W])));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!(status_ack && pending) && !bus_reset) |=> ($stable(live_addr) && $stable(live_en)));

    a_r5_bus_reset_live: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (live_addr == '0 && live_en));

    a_r6_discard_pending: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !pending);

    a_r7_reg_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_code == WR_CODE) |=> $stable(prog_val));

    a_r8_no_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(live_en) |-> !no_match);
endmodule

bind usb_devaddr_ctrl usb_devaddr_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .CODE_W (CODE_W),
    .WR_CODE(WR_CODE),
    .RD_CODE(RD_CODE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_rvalid(cmd_rvalid),
    .bus_reset (bus_reset),
    .status_ack(status_ack),
    .prog_val  (prog_val),
    .pending   (pending),
    .live_addr (live_addr),
    .live_en   (live_en),
    .no_match  (no_match)
);

// File: tb/usb_devaddr_ctrl_test.sv
`timescale 1ns/1ps
module usb_devaddr_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = 8'h00;
    logic [15:0] cmd_wdata = 16'h0000;
    logic [15:0] cmd_rdata;
    logic        cmd_rvalid;
    logic        bus_reset = 1'b0;
    logic        status_ack = 1'b0;
    logic [6:0]  live_addr;
    logic        live_en;
    logic        no_match;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    bit    done     = 1'b0;

    // Behavioural reference state
    int m_reg = 0, m_pend = 0, m_addr = 0, m_en = 0, m_rvalid = 0, m_rdata = 0;

    always #2.5 clk = ~clk;

    usb_devaddr_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata), .cmd_rvalid(cmd_rvalid),
        .bus_reset(bus_reset), .status_ack(status_ack), .live_addr(live_addr),
        .live_en(live_en), .no_match(no_match)
    );

    task automatic check(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("live_addr", int'(live_addr), m_addr);
        check("live_en", int'(live_en), m_en);
        check("no_match (R8)", int'(no_match), (m_en == 0) ? 1 : 0);
        check("cmd_rvalid", int'(cmd_rvalid), m_rvalid);
        if (m_rvalid != 0) check("cmd_rdata", int'(cmd_rdata), m_rdata);
    endtask

    // One clock: apply inputs after negedge, advance model at posedge, compare at next negedge.
    task automatic step(input bit v, input logic [7:0] code, input logic [15:0] wd,
                        input bit br, input bit ack);
        int wr, rd, commit, old_reg;
        cmd_valid = v; cmd_code = code; cmd_wdata = wd; bus_reset = br; status_ack = ack;
        @(posedge clk);
        wr = (v && code == 8'hB6) ? 1 : 0;
        rd = (v && code == 8'hB7) ? 1 : 0;
        old_reg = m_reg;
        commit = (ack && m_pend != 0 && !br) ? 1 : 0;
        if (br) begin
            m_addr = 0; m_en = 1;
        end else if (commit != 0) begin
            m_addr = old_reg % 128; m_en = old_reg / 128;
        end
        if (wr != 0) m_reg = int'(wd) % 256;
        if (br) m_pend = 0;
        else if (wr != 0) m_pend = 1;
        else if (ack) m_pend = 0;
        m_rvalid = rd;
        if (rd != 0) m_rdata = old_reg;
        @(negedge clk);
        cmd_valid = 1'b0; bus_reset = 1'b0; status_ack = 1'b0;
        compare_all();
    endtask

    task automatic wr_cmd(input logic [15:0] d); step(1, 8'hB6, d, 0, 0); endtask
    task automatic rd_cmd();                     step(1, 8'hB7, 16'h0, 0, 0); endtask
    task automatic ack_only();                   step(0, 8'h00, 16'h0, 0, 1); endtask
    task automatic idle();                       step(0, 8'h00, 16'h0, 0, 0); endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        check("reset live_addr", int'(live_addr), 0);
        check("reset live_en", int'(live_en), 0);
        check("reset no_match", int'(no_match), 1);
        check("reset rvalid", int'(cmd_rvalid), 0);
        rd_cmd();
        check("reset readback", int'(cmd_rdata), 0);

        cur_req = "R2";
        wr_cmd(16'h1234);
        rd_cmd();
        check("readback upper byte ignored", int'(cmd_rdata), 16'h0034);
        cur_req = "R3";
        idle(); idle();
        check("no change before ack", int'(live_addr), 0);
        ack_only();
        check("addr after ack", int'(live_addr), 7'h34);
        wr_cmd(16'h00AA);
        ack_only();
        check("enable after ack", int'(live_en), 1);
        cur_req = "R8";
        check("no_match low when enabled", int'(no_match), 0);

        cur_req = "R4";
        ack_only(); ack_only();
        check("ack without pending", int'(live_addr), 7'h2A);

        cur_req = "R7";
        step(1, 8'hB5, 16'h00FF, 0, 0);
        step(1, 8'h36, 16'h0011, 0, 0);
        step(1, 8'hB8, 16'h0000, 0, 0);
        rd_cmd();
        check("other codes leave register", int'(cmd_rdata), 16'h00AA);
        ack_only();
        check("other codes set no pending", int'(live_addr), 7'h2A);

        cur_req = "R5";
        wr_cmd(16'h0015);
        ack_only();
        step(0, 8'h00, 16'h0, 1, 0);
        check("bus reset addr", int'(live_addr), 0);
        check("bus reset enable", int'(live_en), 1);
        rd_cmd();
        check("bus reset keeps register", int'(cmd_rdata), 16'h0015);

        cur_req = "R6";
        wr_cmd(16'h0085);
        step(0, 8'h00, 16'h0, 1, 0);
        ack_only();
        check("pending discarded", int'(live_addr), 0);
        wr_cmd(16'h0086);
        step(0, 8'h00, 16'h0, 1, 1);
        check("reset wins over ack", int'(live_addr), 0);
        ack_only();
        step(1, 8'hB6, 16'h0087, 1, 0);
        ack_only();
        check("write with reset not pending", int'(live_addr), 0);
        rd_cmd();
        check("write with reset stored", int'(cmd_rdata), 16'h0087);

        cur_req = "R9";
        wr_cmd(16'h0011);
        step(1, 8'hB6, 16'h0022, 0, 1);
        check("older value commits", int'(live_addr), 7'h11);
        ack_only();
        check("newer value stays pending", int'(live_addr), 7'h22);

        cur_req = "R8";
        wr_cmd(16'h0005);
        ack_only();
        check("disabled -> no_match", int'(no_match), 1);
        cur_req = "R2";
        step(1, 8'hB7, 16'h0, 0, 0);
        step(1, 8'hB6, 16'h00C3, 0, 0);
        step(1, 8'hB7, 16'h0, 0, 0);
        check("read after write", int'(cmd_rdata), 16'h00C3);
        idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog %s actual=timeout expected=completion", cur_req);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule